// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit binary up-counters that share one system clock. Each counter advances only on a cycle where its selected count strobe is high and its run bit is set. Each counter is compared against its own 8-bit time constant. When the count reaches that constant, the block emits a one-cycle match pulse, and the next count step returns the counter to zero. A wrap from all-ones to zero emits a one-cycle overflow pulse.

Counter 0 counts one of three prescaler strobes, or rising edges on an external pin after that pin has been synchronized. Counter 1 counts one of three prescaler strobes of its own, or the match events of counter 0.

In cascade mode the two counters form one 16-bit counter. Counter 1 then advances only on the carry out of counter 0. The 16-bit value is compared against the two constants joined together. The prescaler, the register file and any waveform output logic sit outside this block.

Top module: `tmr_dual`

## Requirements
- R1: While rst_ni is low, both counts are 0 and all four pulse outputs are low.
- R2: A counter whose run bit is low is 0 from the next clock on and does not count.
- R3: Counter 0 strobe select: 0 = tick1_i, 1 = tick4_i, 2 = tick16_i, 3 = rising edge of ext_i, taken through a two-flop synchronizer and an edge register. The count moves on the third clock edge after the pin rises.
- R4: Counter 1 strobe select (8-bit mode): 0 = tick1_i, 1 = tick16_i, 2 = tick256_i, 3 = a counter 0 match event.
- R5: With a nonzero constant K, a step that brings a counter to K raises its match output for one cycle. That cycle is the one in which the count output first shows K. The next step loads 0, so matches repeat every K+1 steps.
- R6: With a zero constant, the counter runs 0 to 255. Its match is raised on the wrap to 0, in the same cycle as its overflow pulse, every 256 steps.
- R7: The overflow output pulses for one cycle when an increment wraps 255 to 0. It does not pulse when a match returns the count to 0.
- R8: With mode16_i high, counter 1 steps only on the carry of counter 0, and clk1_sel_i has no effect. match1_o marks {cnt1,cnt0} reaching {const1,const0}; the next step clears both counters. match0_o stays low.
- R9: With mode16_i high and both constants zero, match1_o and ovf1_o pulse together on the 16-bit wrap from 0xFFFF to 0.
- R10: Strobes arriving while a run bit is low leave that counter at 0 and produce no match or overflow pulse from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick1_i | input | 1 | Prescaler strobe, every count |
| tick4_i | input | 1 | Prescaler strobe, divide by 4 |
| tick16_i | input | 1 | Prescaler strobe, divide by 16 |
| tick256_i | input | 1 | Prescaler strobe, divide by 256 |
| ext_i | input | 1 | Asynchronous external count pin |
| mode16_i | input | 1 | 1 = cascade the counters as one 16-bit counter |
| clk0_sel_i | input | 2 | Counter 0 strobe select |
| clk1_sel_i | input | 2 | Counter 1 strobe select |
| run0_i | input | 1 | Counter 0 run, low clears |
| run1_i | input | 1 | Counter 1 run, low clears |
| const0_i | input | 8 | Counter 0 time constant |
| const1_i | input | 8 | Counter 1 time constant |
| cnt0_o | output | 8 | Counter 0 value |
| cnt1_o | output | 8 | Counter 1 value |
| match0_o | output | 1 | Counter 0 match pulse |
| match1_o | output | 1 | Counter 1 match pulse, or 16-bit match pulse in cascade mode |
| ovf0_o | output | 1 | Counter 0 overflow pulse |
| ovf1_o | output | 1 | Counter 1 overflow pulse, or 16-bit overflow pulse in cascade mode |

## Verification
A wrong count shows on the count outputs in the cycle right after the step that produced it. A wrong wrap point shows up as a match or overflow pulse that arrives early, arrives late or is missing. It appears at most K+1 steps later, or 256 steps later for a zero constant.

A wrong selector or a stale synchronizer bit makes the count drift away from the strobe pattern within a few strobes. A fault in the cascade carry may stay hidden until the low byte wraps, so the bench runs a full 65,536-step cascade cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    C0_T1  = 2'd0,
    C0_T4  = 2'd1,
    C0_T16 = 2'd2,
    C0_EXT = 2'd3
  } c0_src_e;

  typedef enum logic [1:0] {
    C1_T1    = 2'd0,
    C1_T16   = 2'd1,
    C1_T256  = 2'd2,
    C1_MATCH = 2'd3
  } c1_src_e;

  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
  parameter int unsigned N  = 4,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  src_i,
  input  logic [SW-1:0] sel_i,
  output logic          pick_o
);
  assign pick_o = src_i[sel_i];
endmodule

// File: rtl/tmr_upcnt.sv
module tmr_upcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic         zero_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= zero_i ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] k_i,
  input  logic         step_i,
  output logic         hit_o,
  output logic         top_o
);
  logic k_zero;
  assign k_zero = (k_i == '0);
  // zero constant: the match moves to the wrap
  assign hit_o  = step_i & (k_zero ? (&cnt_i) : (W'(cnt_i + 1'b1) == k_i));
  assign top_o  = ~k_zero & (cnt_i == k_i);
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual #(
  parameter int unsigned W = 8,
  localparam int unsigned W2 = 2 * W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick1_i,
  input  logic         tick4_i,
  input  logic         tick16_i,
  input  logic         tick256_i,
  input  logic         ext_i,
  input  logic         mode16_i,
  input  logic [1:0]   clk0_sel_i,
  input  logic [1:0]   clk1_sel_i,
  input  logic         run0_i,
  input  logic         run1_i,
  input  logic [W-1:0] const0_i,
  input  logic [W-1:0] const1_i,
  output logic [W-1:0] cnt0_o,
  output logic [W-1:0] cnt1_o,
  output logic         match0_o,
  output logic         match1_o,
  output logic         ovf0_o,
  output logic         ovf1_o
);
  import tmr_pkg::*;

  logic ext_rise;
  logic [NUM_SRC-1:0] src0_vec, src1_vec;
  logic src0, src1;
  logic step0, step1_8, step1;
  logic zero0, zero1;
  logic [W-1:0] cnt0, cnt1;
  logic full0, full1;
  logic hit0, top0, hit1, top1, hit16, top16;
  logic m0, m1, v0, v1;

  tmr_edge_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_i),
    .rise_o(ext_rise)
  );

  always_comb begin
    src0_vec         = '0;
    src0_vec[C0_T1]  = tick1_i;
    src0_vec[C0_T4]  = tick4_i;
    src0_vec[C0_T16] = tick16_i;
    src0_vec[C0_EXT] = ext_rise;
  end

  tmr_src_mux #(.N(NUM_SRC)) u_mux0 (
    .src_i (src0_vec),
    .sel_i (clk0_sel_i),
    .pick_o(src0)
  );

  assign step0 = run0_i & src0;

  tmr_match #(.W(W)) u_m0 (
    .cnt_i (cnt0),
    .k_i   (const0_i),
    .step_i(step0),
    .hit_o (hit0),
    .top_o (top0)
  );

  always_comb begin
    src1_vec           = '0;
    src1_vec[C1_T1]    = tick1_i;
    src1_vec[C1_T16]   = tick16_i;
    src1_vec[C1_T256]  = tick256_i;
    src1_vec[C1_MATCH] = hit0;
  end

  tmr_src_mux #(.N(NUM_SRC)) u_mux1 (
    .src_i (src1_vec),
    .sel_i (clk1_sel_i),
    .pick_o(src1)
  );

  assign step1_8 = run1_i & src1;

  tmr_match #(.W(W)) u_m1 (
    .cnt_i (cnt1),
    .k_i   (const1_i),
    .step_i(step1_8),
    .hit_o (hit1),
    .top_o (top1)
  );

  tmr_match #(.W(W2)) u_m16 (
    .cnt_i ({cnt1, cnt0}),
    .k_i   ({const1_i, const0_i}),
    .step_i(step0),
    .hit_o (hit16),
    .top_o (top16)
  );

  always_comb begin
    if (mode16_i) begin
      zero0 = top16;
      zero1 = top16;
      // high byte moves on low-byte carry or on the joint clear
      step1 = run1_i & step0 & (full0 | top16);
      m0    = 1'b0;
      m1    = hit16;
      v0    = step0 & full0 & ~top16;
      v1    = step1 & full0 & full1 & ~top16;
    end else begin
      zero0 = top0;
      zero1 = top1;
      step1 = step1_8;
      m0    = hit0;
      m1    = hit1;
      v0    = step0 & full0 & ~top0;
      v1    = step1_8 & full1 & ~top1;
    end
  end

  tmr_upcnt #(.W(W)) u_cnt0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run0_i),
    .step_i(step0),
    .zero_i(zero0),
    .cnt_o (cnt0),
    .full_o(full0)
  );

  tmr_upcnt #(.W(W)) u_cnt1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run1_i),
    .step_i(step1),
    .zero_i(zero1),
    .cnt_o (cnt1),
    .full_o(full1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match0_o <= 1'b0;
      match1_o <= 1'b0;
      ovf0_o   <= 1'b0;
      ovf1_o   <= 1'b0;
    end else begin
      match0_o <= m0;
      match1_o <= m1;
      ovf0_o   <= v0;
      ovf1_o   <= v1;
    end
  end

  assign cnt0_o = cnt0;
  assign cnt1_o = cnt1;
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode16_i,
  input logic         run0_i,
  input logic         run1_i,
  input logic [W-1:0] const0_i,
  input logic [W-1:0] cnt0_o,
  input logic [W-1:0] cnt1_o,
  input logic         match0_o,
  input logic         ovf0_o
);
  a_r2_run0_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run0_i |=> (cnt0_o == '0));

  a_r2_run1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run1_i |=> (cnt1_o == '0));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0_o != $past(cnt0_o)) |->
      ((cnt0_o == W'($past(cnt0_o) + 1'b1)) || (cnt0_o == '0)));

  a_r5_match_at_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match0_o && ($past(const0_i) != '0)) |-> (cnt0_o == $past(const0_i)));

  a_r7_ovf_is_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf0_o |-> ((cnt0_o == '0) && ($past(cnt0_o) == {W{1'b1}})));

  a_r8_no_low_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode16_i) |-> !match0_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run0_i) |-> (!match0_o && !ovf0_o));
endmodule

bind tmr_dual tmr_dual_chk #(.W(W)) u_chk (.*);

// File: tb/tmr_dual_tb_top.sv
`timescale 1ns/1ps
module tmr_dual_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t1 = 0, t4 = 0, t16 = 0, t256 = 0, ext = 0, mode16 = 0;
  logic [1:0] sel0 = 0, sel1 = 0;
  logic run0 = 0, run1 = 0;
  logic [7:0] k0 = 0, k1 = 0;
  logic [7:0] cnt0, cnt1;
  logic mt0, mt1, ov0, ov1;

  int n_run = 0, n_fail = 0;
  bit checking = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tmr_dual dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tick1_i(t1), .tick4_i(t4), .tick16_i(t16), .tick256_i(t256),
    .ext_i(ext), .mode16_i(mode16),
    .clk0_sel_i(sel0), .clk1_sel_i(sel1),
    .run0_i(run0), .run1_i(run1),
    .const0_i(k0), .const1_i(k1),
    .cnt0_o(cnt0), .cnt1_o(cnt1),
    .match0_o(mt0), .match1_o(mt1), .ovf0_o(ov0), .ovf1_o(ov1)
  );

  // reference model built from the requirements
  logic [7:0] e0, e1;
  logic em0, em1, ev0, ev1;
  logic q0, q1, qp;

  function automatic logic hit8(logic [7:0] c, logic [7:0] k, logic st);
    return st && ((k != 0) ? (8'(c + 1) == k) : (c == 8'hFF));
  endfunction

  function automatic logic hitw(logic [15:0] c, logic [15:0] k, logic st);
    return st && ((k != 0) ? (16'(c + 1) == k) : (c == 16'hFFFF));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0 <= 0; e1 <= 0; em0 <= 0; em1 <= 0; ev0 <= 0; ev1 <= 0;
      q0 <= 0; q1 <= 0; qp <= 0;
    end else begin
      logic rise, tk0, tk1, st0, st1, tp0, tp1, tp16, h0;
      logic [15:0] v16, kk;
      rise = q1 & ~qp;
      qp <= q1; q1 <= q0; q0 <= ext;
      case (sel0)
        2'd0: tk0 = t1;
        2'd1: tk0 = t4;
        2'd2: tk0 = t16;
        default: tk0 = rise;
      endcase
      st0 = run0 & tk0;
      if (!mode16) begin
        h0  = hit8(e0, k0, st0);
        tp0 = (k0 != 0) && (e0 == k0);
        case (sel1)
          2'd0: tk1 = t1;
          2'd1: tk1 = t16;
          2'd2: tk1 = t256;
          default: tk1 = h0;
        endcase
        st1 = run1 & tk1;
        tp1 = (k1 != 0) && (e1 == k1);
        em0 <= h0;
        em1 <= hit8(e1, k1, st1);
        ev0 <= st0 && e0 == 8'hFF && !tp0;
        ev1 <= st1 && e1 == 8'hFF && !tp1;
        e0 <= !run0 ? 8'd0 : st0 ? (tp0 ? 8'd0 : 8'(e0 + 1)) : e0;
        e1 <= !run1 ? 8'd0 : st1 ? (tp1 ? 8'd0 : 8'(e1 + 1)) : e1;
      end else begin
        v16  = {e1, e0};
        kk   = {k1, k0};
        tp16 = (kk != 0) && (v16 == kk);
        st1  = run1 & st0 & ((e0 == 8'hFF) | tp16);
        em0 <= 1'b0;
        em1 <= hitw(v16, kk, st0);
        ev0 <= st0 && e0 == 8'hFF && !tp16;
        ev1 <= st1 && v16 == 16'hFFFF && !tp16;
        e0 <= !run0 ? 8'd0 : st0 ? (tp16 ? 8'd0 : 8'(e0 + 1)) : e0;
        e1 <= !run1 ? 8'd0 : st1 ? (tp16 ? 8'd0 : 8'(e1 + 1)) : e1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      chk(cnt0 == e0, tag, "cnt0", cnt0, e0);
      chk(cnt1 == e1, tag, "cnt1", cnt1, e1);
      chk(mt0 == em0, tag, "match0", mt0, em0);
      chk(mt1 == em1, tag, "match1", mt1, em1);
      chk(ov0 == ev0, tag, "ovf0", ov0, ev0);
      chk(ov1 == ev1, tag, "ovf1", ov1, ev1);
    end
  end

  task automatic drive(int n, bit hold_t1, bit rand_run);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t1   = hold_t1 ? 1'b1 : 1'($urandom % 2);
      t4   = ($urandom % 4) == 0;
      t16  = ($urandom % 8) == 0;
      t256 = ($urandom % 16) == 0;
      if (($urandom % 5) == 0) ext = ~ext;
      if (rand_run && ($urandom % 40) == 0) run0 = ~run0;
      if (rand_run && ($urandom % 40) == 0) run1 = ~run1;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cnt0 == 0 && cnt1 == 0, "R1", "counts in reset", {cnt1, cnt0}, 0);
    chk({mt0, mt1, ov0, ov1} == 0, "R1", "pulses in reset", {mt0, mt1, ov0, ov1}, 0);
    @(negedge clk); rst_n = 1'b1; checking = 1;

    // R10: strobes with run low
    tag = "R10"; run0 = 0; run1 = 0; k0 = 0; k1 = 0;
    drive(300, 1'b1, 1'b0);
    chk(cnt0 == 0 && cnt1 == 0, "R10", "counts while stopped", {cnt1, cnt0}, 0);

    // R3: each counter-0 source
    tag = "R3"; run0 = 1; run1 = 1;
    for (int s = 0; s < 4; s++) begin
      sel0 = 2'(s); k0 = 8'(3 + $urandom % 7);
      drive(400, 1'b0, 1'b0);
    end

    // R4: each counter-1 source
    tag = "R4"; sel0 = 0;
    for (int s = 0; s < 4; s++) begin
      sel1 = 2'(s); k0 = 8'(1 + $urandom % 4); k1 = 8'(2 + $urandom % 5);
      drive(400, 1'b0, 1'b0);
    end

    // R5: nonzero constants, corner values 1 and 255 included
    tag = "R5"; sel1 = 0;
    k0 = 8'd1; k1 = 8'd255; drive(600, 1'b1, 1'b0);
    k0 = 8'd6; k1 = 8'd2;   drive(300, 1'b0, 1'b0);

    // R6: zero constant, match at wrap
    tag = "R6"; k0 = 0; k1 = 0; run0 = 0; run1 = 0;
    drive(2, 1'b1, 1'b0); run0 = 1; run1 = 1;
    drive(600, 1'b1, 1'b0);

    // R7: wrap versus match-clear with constant 255
    tag = "R7"; k0 = 8'd255; k1 = 0;
    drive(600, 1'b1, 1'b0);

    // R2: run bits toggling at random
    tag = "R2"; k0 = 8'd9; k1 = 8'd13;
    drive(1500, 1'b0, 1'b1);
    run0 = 1; run1 = 1;

    // R8: cascade with small 16-bit constant, clk1 select ignored
    tag = "R8"; mode16 = 1; sel0 = 0; sel1 = 2'd2; k1 = 8'd2; k0 = 8'd5;
    drive(3000, 1'b1, 1'b0);
    sel1 = 2'd3; drive(500, 1'b0, 1'b0);

    // R9: full 16-bit wrap with zero constants
    tag = "R9"; k0 = 0; k1 = 0; run0 = 0; run1 = 0;
    drive(2, 1'b1, 1'b0); run0 = 1; run1 = 1;
    drive(65600, 1'b1, 1'b0);

    checking = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule